// File: doc/BRIEF.md
# Inbound MSI Decode and Endpoint Ownership Check

This block takes inbound message-signalled interrupt writes from the bus side of a host bridge and turns each one into an interrupt trigger for one source. A write carries a 64-bit address, 16 bits of data and, when it is known, the number of the partitionable endpoint that issued it. The block builds a source number from address and data and rejects it if it lies outside the configured source range. When an endpoint number comes with the write, the block reads that source's vector entry through a memory request port and rejects the write unless the entry names the same endpoint.

A second entry point takes a free-form interrupt register write. The written value is used as the address, with data zero and no endpoint. A lock flag is set while such a write is in flight and is cleared once its outcome is reported. The block also holds the global base number of its sources and the source count. An accepted write yields a one-cycle trigger. A rejected write yields a one-cycle discard pulse with a reason code. Pending/queued gating of triggers is left to the consumer.

Top module: `msi_decode`

## Requirements
- R1: The source number is bits [19:4] of the address, OR-ed with data bits [4:0] zero-extended to 16 bits. No other address or data bit affects it, and it appears on `trig_src` and on `mem_idx`.
- R2: A source number greater than or equal to the current source count is discarded with `drop_reason` = 2'b01. There is no trigger and no memory request.
- R3: With `msi_pe_valid` high, one read of the entry at index source number is requested. `mem_req` and `mem_idx` are held until `mem_rvalid`. The endpoint field is `mem_rdata[PE_LSB +: PE_W]`. A match gives a trigger. A mismatch gives a discard with `drop_reason` = 2'b10.
- R4: With `msi_pe_valid` low, no memory request is made and the trigger or range discard appears exactly one cycle after the accepting edge.
- R5: A read response with `mem_rerr` high gives a discard with `drop_reason` = 2'b11 and no trigger.
- R6: A free-form write (`ffi_we`) behaves as an MSI with address `ffi_value`, data 0 and no endpoint. `ffi_lock` rises on the accepting edge and falls on the edge that reports its outcome.
- R7: A configuration write stores `cfg_base` and stores `cfg_count` clamped to MAX_SRC. Both are visible on `base_num` and `src_count` after the next edge. After reset both are 0.
- R8: Every trigger or discard is a single-cycle pulse. During a trigger, `trig_irq` = `base_num` + source number.
- R9: `in_ready` is low from the accepting edge until the outcome edge, and writes presented while it is low are ignored. When an MSI and a free-form write are presented together, the MSI is taken and the free-form write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | BASE_W | Global number of source 0 |
| cfg_count | input | 32 | Requested source count |
| base_num | output | BASE_W | Stored base number |
| src_count | output | CNT_W | Stored, clamped source count |
| msi_valid | input | 1 | MSI write present |
| msi_addr | input | 64 | MSI address |
| msi_data | input | 16 | MSI data |
| msi_pe_valid | input | 1 | Endpoint number supplied |
| msi_pe | input | PE_W | Issuing endpoint number |
| ffi_we | input | 1 | Free-form interrupt write strobe |
| ffi_value | input | 64 | Free-form written value |
| ffi_lock | output | 1 | Free-form write in flight |
| in_ready | output | 1 | Block idle, writes accepted |
| mem_req | output | 1 | Vector entry read request |
| mem_idx | output | 16 | Entry index (source number) |
| mem_rvalid | input | 1 | Read response valid |
| mem_rerr | input | 1 | Read response error |
| mem_rdata | input | ENTRY_W | Vector entry contents |
| trig_valid | output | 1 | Trigger pulse |
| trig_src | output | 16 | Local source number |
| trig_irq | output | BASE_W | Global interrupt number |
| drop_valid | output | 1 | Discard pulse |
| drop_reason | output | 2 | 01 range, 10 owner mismatch, 11 fetch error |

## Verification
A write with no endpoint has its trigger or range discard due one edge after the accepting edge. The bench therefore samples at the falling edge after that one and also requires that no memory request appeared. A write with an endpoint has its outcome due on the edge that samples the bench memory's response, which comes two falling edges after the request shows up. For those writes the bench walks edge by edge up to a bound. A falling edge after each outcome is used to confirm that the pulse is gone, and the lock and ready flags are sampled at the falling edge right after the accepting edge.

// File: rtl/msi_dec_pkg.sv
// Package: shared types for the MSI decode block.
// Assumes: discard codes are two bits wide and nonzero for a real discard.
package msi_dec_pkg;
    typedef enum logic [1:0] {
        DROP_NONE  = 2'b00,
        DROP_RANGE = 2'b01,
        DROP_OWNER = 2'b10,
        DROP_FETCH = 2'b11
    } drop_reason_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/msi_src_decode.sv
// msi_src_decode: forms a source number from an MSI address and data word.
// Assumes: SRC_W exceeds DATA_BITS; purely combinational.
module msi_src_decode #(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 16,
    parameter int SRC_W     = 16,
    parameter int ADDR_LSB  = 4,
    parameter int DATA_BITS = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [SRC_W-1:0]  src
);
    // Merge the shifted address window with the low data bits.
    always_comb begin
        src = addr[ADDR_LSB +: SRC_W] | SRC_W'(data[DATA_BITS-1:0]);
    end
endmodule

// File: rtl/msi_cfg_regs.sv
// msi_cfg_regs: holds the global base number and the clamped source count.
// Assumes: a write takes effect on the clock edge that samples cfg_we.
module msi_cfg_regs #(
    parameter int BASE_W  = 24,
    parameter int MAX_SRC = 2048,
    parameter int CNT_W   = $clog2(MAX_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [31:0]       cfg_count,
    output logic [BASE_W-1:0] base_q,
    output logic [CNT_W-1:0]  count_q
);
    localparam logic [31:0] MAX_WIDE = 32'(MAX_SRC);

    // Store base and clamped count on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
        end else if (cfg_we) begin
            base_q  <= cfg_base;
            count_q <= (cfg_count > MAX_WIDE) ? CNT_W'(MAX_SRC) : cfg_count[CNT_W-1:0];
        end
    end

    // R7
    count_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_q) <= MAX_WIDE);
endmodule

// File: rtl/msi_ctrl.sv
// msi_ctrl: accepts one write at a time, range-checks it, optionally fetches
// the vector entry to confirm endpoint ownership, then reports the outcome.
// Assumes: the memory side answers every request with exactly one rvalid.
module msi_ctrl
    import msi_dec_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int PE_W   = 8,
    parameter int BASE_W = 24,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [SRC_W-1:0]  msi_src,
    input  logic              msi_pe_valid,
    input  logic [PE_W-1:0]   msi_pe,
    input  logic              ffi_we,
    input  logic [SRC_W-1:0]  ffi_src,
    input  logic [CNT_W-1:0]  count_q,
    input  logic [BASE_W-1:0] base_q,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [PE_W-1:0]   entry_pe,
    output logic              in_ready,
    output logic              ffi_lock,
    output logic              mem_req,
    output logic [SRC_W-1:0]  mem_idx,
    output logic              trig_valid,
    output logic [SRC_W-1:0]  trig_src,
    output logic [BASE_W-1:0] trig_irq,
    output logic              drop_valid,
    output drop_reason_e      drop_reason
);
    ctrl_state_e          state;
    logic [SRC_W-1:0]     src_q;
    logic                 pev_q;
    logic [PE_W-1:0]      pe_q;
    logic                 out_of_range;

    // Range test against the current count, widened to avoid truncation.
    always_comb begin
        out_of_range = (32'(src_q) >= 32'(count_q));
    end

    assign in_ready = (state == ST_IDLE);
    assign mem_idx  = src_q;
    assign trig_src = src_q;
    assign trig_irq = base_q + BASE_W'(src_q);

    // Sequence accept, range check, entry fetch and outcome reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            src_q       <= '0;
            pev_q       <= 1'b0;
            pe_q        <= '0;
            ffi_lock    <= 1'b0;
            mem_req     <= 1'b0;
            trig_valid  <= 1'b0;
            drop_valid  <= 1'b0;
            drop_reason <= DROP_NONE;
        end else begin
            trig_valid  <= 1'b0;
            drop_valid  <= 1'b0;
            drop_reason <= DROP_NONE;
            case (state)
                ST_IDLE: begin
                    if (msi_valid) begin
                        src_q <= msi_src;
                        pev_q <= msi_pe_valid;
                        pe_q  <= msi_pe;
                        state <= ST_CHECK;
                    end else if (ffi_we) begin
                        src_q    <= ffi_src;
                        pev_q    <= 1'b0;
                        pe_q     <= '0;
                        ffi_lock <= 1'b1;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (out_of_range) begin
                        drop_valid  <= 1'b1;
                        drop_reason <= DROP_RANGE;
                        ffi_lock    <= 1'b0;
                        state       <= ST_IDLE;
                    end else if (pev_q) begin
                        mem_req <= 1'b1;
                        state   <= ST_FETCH;
                    end else begin
                        trig_valid <= 1'b1;
                        ffi_lock   <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        mem_req <= 1'b0;
                        state   <= ST_IDLE;
                        if (mem_rerr) begin
                            drop_valid  <= 1'b1;
                            drop_reason <= DROP_FETCH;
                        end else if (entry_pe != pe_q) begin
                            drop_valid  <= 1'b1;
                            drop_reason <= DROP_OWNER;
                        end else begin
                            trig_valid <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid || drop_valid) |=> !(trig_valid || drop_valid));

    // R4
    fetch_needs_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> pev_q);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_idx)));

    // R6
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ffi_lock) |-> (trig_valid || drop_valid));

    // R9
    busy_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid || drop_valid) |-> in_ready);
endmodule

// File: rtl/msi_decode.sv
// msi_decode: top of the inbound MSI decode and endpoint ownership check.
// Assumes: one write in flight at a time; the memory port returns one
// response per request, in any number of cycles.
module msi_decode
    import msi_dec_pkg::*;
#(
    parameter int MAX_SRC = 2048,
    parameter int BASE_W  = 24,
    parameter int PE_W    = 8,
    parameter int PE_LSB  = 16,
    parameter int ENTRY_W = 64,
    parameter int CNT_W   = $clog2(MAX_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [31:0]        cfg_count,
    output logic [BASE_W-1:0]  base_num,
    output logic [CNT_W-1:0]   src_count,
    input  logic               msi_valid,
    input  logic [63:0]        msi_addr,
    input  logic [15:0]        msi_data,
    input  logic               msi_pe_valid,
    input  logic [PE_W-1:0]    msi_pe,
    input  logic               ffi_we,
    input  logic [63:0]        ffi_value,
    output logic               ffi_lock,
    output logic               in_ready,
    output logic               mem_req,
    output logic [15:0]        mem_idx,
    input  logic               mem_rvalid,
    input  logic               mem_rerr,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               trig_valid,
    output logic [15:0]        trig_src,
    output logic [BASE_W-1:0]  trig_irq,
    output logic               drop_valid,
    output logic [1:0]         drop_reason
);
    localparam int SRC_W = 16;

    logic [SRC_W-1:0] msi_src;
    logic [SRC_W-1:0] ffi_src;
    logic [PE_W-1:0]  entry_pe;
    drop_reason_e     reason_e;

    assign entry_pe    = mem_rdata[PE_LSB +: PE_W];
    assign drop_reason = reason_e;

    msi_src_decode #(.ADDR_W(64), .DATA_W(16), .SRC_W(SRC_W)) u_msi_dec (
        .addr (msi_addr),
        .data (msi_data),
        .src  (msi_src)
    );

    msi_src_decode #(.ADDR_W(64), .DATA_W(16), .SRC_W(SRC_W)) u_ffi_dec (
        .addr (ffi_value),
        .data (16'h0000),
        .src  (ffi_src)
    );

    msi_cfg_regs #(.BASE_W(BASE_W), .MAX_SRC(MAX_SRC), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_base  (cfg_base),
        .cfg_count (cfg_count),
        .base_q    (base_num),
        .count_q   (src_count)
    );

    msi_ctrl #(.SRC_W(SRC_W), .PE_W(PE_W), .BASE_W(BASE_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .msi_valid    (msi_valid),
        .msi_src      (msi_src),
        .msi_pe_valid (msi_pe_valid),
        .msi_pe       (msi_pe),
        .ffi_we       (ffi_we),
        .ffi_src      (ffi_src),
        .count_q      (src_count),
        .base_q       (base_num),
        .mem_rvalid   (mem_rvalid),
        .mem_rerr     (mem_rerr),
        .entry_pe     (entry_pe),
        .in_ready     (in_ready),
        .ffi_lock     (ffi_lock),
        .mem_req      (mem_req),
        .mem_idx      (mem_idx),
        .trig_valid   (trig_valid),
        .trig_src     (trig_src),
        .trig_irq     (trig_irq),
        .drop_valid   (drop_valid),
        .drop_reason  (reason_e)
    );
endmodule

// File: tb/msi_decode_tb.sv
// Bench for msi_decode: vector table walk, then directed corner cases.
module msi_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_base = '0;
    logic [31:0] cfg_count = '0;
    logic [23:0] base_num;
    logic [11:0] src_count;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [15:0] msi_data = '0;
    logic        msi_pe_valid = 1'b0;
    logic [7:0]  msi_pe = '0;
    logic        ffi_we = 1'b0;
    logic [63:0] ffi_value = '0;
    logic        ffi_lock, in_ready, mem_req;
    logic [15:0] mem_idx;
    logic        mem_rvalid = 1'b0;
    logic        mem_rerr = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        trig_valid;
    logic [15:0] trig_src;
    logic [23:0] trig_irq;
    logic        drop_valid;
    logic [1:0]  drop_reason;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    logic [1:0] lat = '0;

    always #10 clk = ~clk;

    msi_decode dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .base_num(base_num), .src_count(src_count),
        .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
        .msi_pe_valid(msi_pe_valid), .msi_pe(msi_pe), .ffi_we(ffi_we),
        .ffi_value(ffi_value), .ffi_lock(ffi_lock), .in_ready(in_ready),
        .mem_req(mem_req), .mem_idx(mem_idx), .mem_rvalid(mem_rvalid),
        .mem_rerr(mem_rerr), .mem_rdata(mem_rdata), .trig_valid(trig_valid),
        .trig_src(trig_src), .trig_irq(trig_irq), .drop_valid(drop_valid),
        .drop_reason(drop_reason)
    );

    // Entry memory model: endpoint = idx[7:0]^8'h5A at bits [23:16]; idx 40 errors.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            lat        <= '0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            lat        <= '0;
        end else if (mem_req) begin
            if (lat == 2'd0) req_cnt <= req_cnt + 1;
            if (lat == 2'd1) begin
                mem_rvalid <= 1'b1;
                mem_rerr   <= (mem_idx == 16'd40);
                mem_rdata  <= 64'(mem_idx[7:0] ^ 8'h5A) << 16;
            end else begin
                lat <= lat + 2'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one write, wait for its outcome and check it.
    task automatic run(input logic [63:0] addr, input logic [15:0] data,
                       input logic pev, input logic [7:0] pe, input bit is_ffi,
                       input logic exp_drop, input logic [1:0] exp_reason,
                       input logic [15:0] exp_src, input string req);
        int n;
        int req0;
        bit done;
        @(negedge clk);
        if (is_ffi) begin
            ffi_we = 1'b1; ffi_value = addr;
        end else begin
            msi_valid = 1'b1; msi_addr = addr; msi_data = data;
            msi_pe_valid = pev; msi_pe = pe;
        end
        req0 = req_cnt;
        @(posedge clk);
        @(negedge clk);
        msi_valid = 1'b0; ffi_we = 1'b0; msi_pe_valid = 1'b0;
        chk(in_ready == 1'b0, "R9", "ready while busy", 64'(in_ready), 64'd0);
        if (is_ffi) chk(ffi_lock == 1'b1, "R6", "lock set", 64'(ffi_lock), 64'd1);
        n = 0; done = 0;
        while (!done && n < 20) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (trig_valid || drop_valid) done = 1;
        end
        chk(done, req, "outcome seen", 64'(done), 64'd1);
        chk(drop_valid == exp_drop && trig_valid == !exp_drop, req, "outcome kind",
            64'({trig_valid, drop_valid}), 64'({!exp_drop, exp_drop}));
        chk(drop_reason == (exp_drop ? exp_reason : 2'b00), req, "drop reason",
            64'(drop_reason), 64'(exp_drop ? exp_reason : 2'b00));
        chk(mem_idx == exp_src, "R1", "source number", 64'(mem_idx), 64'(exp_src));
        if (!exp_drop)
            chk(trig_irq == base_num + 24'(exp_src), "R8", "global number",
                64'(trig_irq), 64'(base_num + 24'(exp_src)));
        if (!pev) begin
            chk(n == 1, "R4", "latency", 64'(n), 64'd1);
            chk(req_cnt == req0, "R4", "no fetch", 64'(req_cnt - req0), 64'd0);
        end else if (exp_reason != 2'b01 || !exp_drop) begin
            chk(req_cnt == req0 + 1, "R3", "one fetch", 64'(req_cnt - req0), 64'd1);
        end
        if (is_ffi) chk(ffi_lock == 1'b0, "R6", "lock cleared", 64'(ffi_lock), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk(!trig_valid && !drop_valid, "R8", "pulse width",
            64'({trig_valid, drop_valid}), 64'd0);
    endtask

    typedef struct packed {
        logic [63:0] addr;
        logic [15:0] data;
        logic        pev;
        logic [7:0]  pe;
        logic        drop;
        logic [1:0]  reason;
        logic [15:0] src;
    } vec_t;

    // R1 R2 R3 R5: stimulus and expected outcome (count 100).
    localparam vec_t VECS [0:8] = '{
        '{64'h120, 16'h0005, 1'b0, 8'h00, 1'b0, 2'b00, 16'd23},
        '{64'h050, 16'h001A, 1'b0, 8'h00, 1'b0, 2'b00, 16'd31},
        '{64'hFFFF_FFFF_0000_0630, 16'h0000, 1'b0, 8'h00, 1'b0, 2'b00, 16'd99},
        '{64'h640, 16'h0000, 1'b0, 8'h00, 1'b1, 2'b01, 16'd100},
        '{64'h100, 16'hFFE0, 1'b0, 8'h00, 1'b0, 2'b00, 16'd16},
        '{64'h140, 16'h0000, 1'b1, 8'h4E, 1'b0, 2'b00, 16'd20},
        '{64'h150, 16'h0000, 1'b1, 8'h00, 1'b1, 2'b10, 16'd21},
        '{64'h280, 16'h0000, 1'b1, 8'h72, 1'b1, 2'b11, 16'd40},
        '{64'h0010_0000, 16'h0003, 1'b0, 8'h00, 1'b0, 2'b00, 16'd3}
    };

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(in_ready && !trig_valid && !drop_valid && !mem_req && !ffi_lock, "R9",
            "reset outputs", 64'({in_ready, trig_valid, drop_valid, mem_req, ffi_lock}),
            64'b10000);
        chk(src_count == 0 && base_num == 0, "R7", "reset config",
            64'({base_num, src_count}), 64'd0);
        // R2 with count 0 after reset: source 0 is out of range
        run(64'h0, 16'h0, 1'b0, 8'h0, 1'b0, 1'b1, 2'b01, 16'd0, "R2");
        // R7 clamp
        cfg_we = 1'b1; cfg_base = 24'h000123; cfg_count = 32'd5000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(src_count == 12'd2048 && base_num == 24'h123, "R7", "clamp",
            64'({base_num, src_count}), 64'({24'h123, 12'd2048}));
        cfg_we = 1'b1; cfg_base = 24'h001000; cfg_count = 32'd100;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(src_count == 12'd100 && base_num == 24'h1000, "R7", "store",
            64'({base_num, src_count}), 64'({24'h1000, 12'd100}));

        for (int i = 0; i < 9; i++)
            run(VECS[i].addr, VECS[i].data, VECS[i].pev, VECS[i].pe, 1'b0,
                VECS[i].drop, VECS[i].reason, VECS[i].src, "R1/R2/R3/R5 vector");

        // R6 free-form writes: in range and out of range
        run(64'h2A0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 2'b00, 16'd42, "R6");
        run(64'h1000, 16'h0, 1'b0, 8'h0, 1'b1, 1'b1, 2'b01, 16'd256, "R6");

        // R9 writes while busy are ignored
        begin
            int seen;
            @(negedge clk);
            msi_valid = 1'b1; msi_addr = 64'h140; msi_data = 16'h0;
            msi_pe_valid = 1'b1; msi_pe = 8'h4E;
            @(posedge clk);
            @(negedge clk);
            msi_addr = 64'h050; msi_pe_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(in_ready == 1'b0, "R9", "busy in fetch", 64'(in_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
            msi_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(trig_valid && trig_src == 16'd20, "R9", "first write kept",
                64'(trig_src), 64'd20);
            seen = 0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (trig_valid || drop_valid) seen++;
            end
            chk(seen == 0, "R9", "busy write ignored", 64'(seen), 64'd0);
        end

        // R9 MSI wins over a simultaneous free-form write
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = 64'h070; msi_data = 16'h0; msi_pe_valid = 1'b0;
        ffi_we = 1'b1; ffi_value = 64'h090;
        @(posedge clk);
        @(negedge clk);
        msi_valid = 1'b0; ffi_we = 1'b0;
        chk(ffi_lock == 1'b0, "R9", "ffi not taken", 64'(ffi_lock), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk(trig_valid && trig_src == 16'd7, "R9", "msi taken", 64'(trig_src), 64'd7);
        begin
            int seen2;
            seen2 = 0;
            for (int k = 0; k < 5; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (trig_valid || drop_valid) seen2++;
            end
            chk(seen2 == 0, "R9", "no late ffi", 64'(seen2), 64'd0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule